// File: doc/BRIEF.md
# Timer Interrupt Routing Controller

This block sits between four event timers and the interrupt fabric of the system. Each timer raises an interrupt as a level or as a one-cycle pulse. The block steers each interrupt to a line on the legacy PIC input vector, to a line on the IO-APIC input vector, or turns it into a memory-write message for the processor. A global legacy switch replaces the routes of the two lowest timers with fixed lines. Every timer also has a per-timer set of IRQ numbers it may use, and any other selection is dropped.

Message delivery is chosen per timer. A timer that has its message enable set and is configured edge-triggered sends one write per event. The write carries that timer's own address and data. Such a timer drives no IRQ line. Message requests go into a pending flag per timer and are granted to a single write channel in fixed priority order, so back-pressure from the channel loses no event.

Top module: `timer_irq_router`

## Requirements
- R1: `cap_mask` reports one bit per IRQ number for each timer, in the field `cap_mask[t*24 +: 24]`. For timers 0 and 1 only bits 20–23 are set. Timer 2 sets bits 11 and 20–23. Timer 3 sets bits 12 and 20–23.
- R2: With `legacy_en` low, an interrupting timer whose 5-bit select `route_sel[t*5 +: 5]` names an IRQ in its capability set drives that IRQ on `ioapic_irq`. When that IRQ is below 16 (IRQ11, IRQ12), it drives the same line on `pic_irq` as well.
- R3: A select outside the timer's capability set, including any value 24 or above, drives no line on either vector.
- R4: With `legacy_en` high, timer 0 drives `pic_irq[0]` and `ioapic_irq[2]`, and timer 1 drives `pic_irq[8]` and `ioapic_irq[8]`. Their selects are ignored. Timers 2 and 3 keep their own routing.
- R5: IRQ outputs follow `tmr_evt` in the same cycle. A level-triggered timer (`tmr_level[t]`=1) holds its line for as long as its input is high. An edge timer's one-cycle pulse gives a one-cycle line pulse.
- R6: A timer is in message mode exactly when `msg_en[t]`=1 and `tmr_level[t]`=0. In message mode its events drive no IRQ line. With `msg_en[t]`=1 and level triggering, normal routing applies.
- R7: Each message-mode event produces exactly one write with address `msg_addr[t*32 +: 32]` and data `msg_data[t*32 +: 32]`. When the channel is free, `wr_valid` is high in the cycle after the event's clock edge.
- R8: Pending message requests are granted lowest timer number first. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady, and the other requests stay pending until they are issued.
- R9: Message mode works for timers 0 and 1 while `legacy_en` is high.
- R10: After reset, `wr_valid` is low and no message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Global fixed-route override |
| tmr_evt | input | 4 | Per-timer interrupt (pulse or level) |
| tmr_level | input | 4 | 1 = level-triggered, 0 = edge-triggered |
| route_sel | input | 20 | Per-timer 5-bit destination IRQ number |
| msg_en | input | 4 | Per-timer message-delivery enable |
| msg_addr | input | 128 | Per-timer 32-bit message address |
| msg_data | input | 128 | Per-timer 32-bit message value |
| wr_ready | input | 1 | Write channel accepts the current write |
| cap_mask | output | 96 | Per-timer legal IRQ set |
| pic_irq | output | 16 | Legacy PIC input lines |
| ioapic_irq | output | 24 | IO-APIC input lines |
| wr_valid | output | 1 | Write request present |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |

## Verification
Several properties are checked on every cycle by the assertions:
- no IO-APIC line rises outside the union of the capability sets and the two fixed legacy lines;
- an interrupt made only of message-mode events leaves both vectors quiet;
- a stalled write keeps its address and data;
- at most one request is granted per cycle;
- a message event on a free channel is followed by a valid write.

Other behaviour needs the bench's scenarios:
- which exact line each select reaches;
- the fixed legacy lines;
- the grant order across several stalled cycles;
- the exact address and data of each write.

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
  parameter int NT   = 4,
  parameter int NIRQ = 24,
  parameter int NPIC = 16,
  parameter int SELW = 5,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               legacy_en,
  input  logic [NT-1:0]      tmr_evt,
  input  logic [NT-1:0]      tmr_level,
  input  logic [NT*SELW-1:0] route_sel,
  input  logic [NT-1:0]      msg_en,
  input  logic [NT*AW-1:0]   msg_addr,
  input  logic [NT*DW-1:0]   msg_data,
  input  logic               wr_ready,
  output logic [NT*NIRQ-1:0] cap_mask,
  output logic [NPIC-1:0]    pic_irq,
  output logic [NIRQ-1:0]    ioapic_irq,
  output logic               wr_valid,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data
);
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  logic [NT-1:0] msg_act, irq_act, pend, req, gnt, take;
  logic [IW-1:0] gidx;
  logic          slot_free;
  logic [NIRQ-1:0] cap_any;

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_cap
      logic [NIRQ-1:0] c;
      always_comb begin
        c = '0;
        for (int i = 20; i < 24 && i < NIRQ; i++) c[i] = 1'b1;
        if (g == 2 && NIRQ > 11) c[11] = 1'b1;
        if (g == 3 && NIRQ > 12) c[12] = 1'b1;
      end
      assign cap_mask[g*NIRQ +: NIRQ] = c;
    end
  endgenerate

  assign msg_act = msg_en & ~tmr_level;
  assign irq_act = tmr_evt & ~msg_act;

  always_comb begin
    pic_irq    = '0;
    ioapic_irq = '0;
    for (int t = 0; t < NT; t++) begin
      int s;
      s = int'(route_sel[t*SELW +: SELW]);
      if (irq_act[t]) begin
        if (legacy_en && t == 0) begin
          pic_irq[0]    = 1'b1;
          ioapic_irq[2] = 1'b1;
        end else if (legacy_en && t == 1) begin
          pic_irq[8]    = 1'b1;
          ioapic_irq[8] = 1'b1;
        end else if (s < NIRQ && cap_mask[t*NIRQ + s]) begin
          ioapic_irq[s] = 1'b1;
          if (s < NPIC) pic_irq[s] = 1'b1;
        end
      end
    end
  end

  assign req       = pend | (tmr_evt & msg_act);
  assign slot_free = !wr_valid || wr_ready;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int t = NT-1; t >= 0; t--)
      if (req[t]) begin
        gnt  = '0;
        gnt[t] = 1'b1;
        gidx = IW'(t);
      end
  end

  assign take = slot_free ? gnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      pend <= req & ~take;
      if (slot_free) begin
        wr_valid <= |req;
        if (|req) begin
          wr_addr <= msg_addr[gidx*AW +: AW];
          wr_data <= msg_data[gidx*DW +: DW];
        end
      end
    end
  end

  always_comb begin
    cap_any = '0;
    for (int t = 0; t < NT; t++) cap_any = cap_any | cap_mask[t*NIRQ +: NIRQ];
  end

  a_r3_io_in_caps: assert property (@(posedge clk) disable iff (!rst_n)
    (ioapic_irq & ~(cap_any | (legacy_en ? NIRQ'(24'h000104) : '0))) == '0);
  a_r6_msg_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_evt & ~msg_act) == '0) |-> (pic_irq == '0 && ioapic_irq == '0));
  a_r4_legacy_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en && tmr_evt[0] && !msg_act[0]) |-> (pic_irq[0] && ioapic_irq[2]));
  a_r7_issue: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_evt & msg_act) != '0 && slot_free) |=> wr_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(take));
endmodule

// File: tb/test_timer_irq_router.sv
module test_timer_irq_router;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, legacy_en, wr_ready;
  logic [3:0] tmr_evt, tmr_level, msg_en;
  logic [19:0] route_sel;
  logic [127:0] msg_addr, msg_data;
  logic [95:0] cap_mask;
  logic [15:0] pic_irq;
  logic [23:0] ioapic_irq;
  logic wr_valid;
  logic [31:0] wr_addr, wr_data;

  timer_irq_router i_timer_irq_router (
    .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_evt(tmr_evt),
    .tmr_level(tmr_level), .route_sel(route_sel), .msg_en(msg_en),
    .msg_addr(msg_addr), .msg_data(msg_data), .wr_ready(wr_ready),
    .cap_mask(cap_mask), .pic_irq(pic_irq), .ioapic_irq(ioapic_irq),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  typedef struct packed {
    logic        leg;
    logic [19:0] sel;
    logic [3:0]  evt;
    logic [3:0]  lvl;
    logic [3:0]  men;
    logic [15:0] pic;
    logic [23:0] io;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, {5'd12,5'd11,5'd21,5'd20}, 4'b1111, 4'b1111, 4'b0000, 16'h1800, 24'h301800},
    '{1'b0, {5'd23,5'd21,5'd22,5'd5 }, 4'b1111, 4'b1111, 4'b0000, 16'h0000, 24'hE00000},
    '{1'b1, {5'd12,5'd11,5'd21,5'd20}, 4'b1111, 4'b1111, 4'b0000, 16'h1901, 24'h001904},
    '{1'b0, {5'd11,5'd12,5'd31,5'd23}, 4'b1111, 4'b1111, 4'b0000, 16'h0000, 24'h800000},
    '{1'b0, {5'd12,5'd11,5'd21,5'd20}, 4'b0101, 4'b1111, 4'b0000, 16'h0800, 24'h100800},
    '{1'b0, {5'd12,5'd11,5'd21,5'd20}, 4'b0001, 4'b0000, 4'b0001, 16'h0000, 24'h000000},
    '{1'b0, {5'd12,5'd11,5'd21,5'd20}, 4'b0001, 4'b0001, 4'b0001, 16'h0000, 24'h100000},
    '{1'b1, {5'd12,5'd11,5'd21,5'd20}, 4'b0011, 4'b0000, 4'b0010, 16'h0001, 24'h000004}
  };

  int runs = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; legacy_en = 0; wr_ready = 1; tmr_evt = 0; tmr_level = 0;
    msg_en = 0; route_sel = 0;
    for (int t = 0; t < 4; t++) begin
      msg_addr[t*32 +: 32] = 32'hFEE0_0000 + 32'(t*16);
      msg_data[t*32 +: 32] = 32'hA0 + 32'(t);
    end
    repeat (3) step();
    rst_n = 1;
    #1;
    check("R10 wr_valid after reset", wr_valid, 0);
    check("R1 capability mask", cap_mask,
          {24'hF01000, 24'hF00800, 24'hF00000, 24'hF00000});

    // R2 R3 R4 R5 R6 routing vectors
    for (int i = 0; i < 8; i++) begin
      step();
      legacy_en = VEC[i].leg; route_sel = VEC[i].sel; tmr_level = VEC[i].lvl;
      msg_en = VEC[i].men; tmr_evt = VEC[i].evt;
      #1;
      check($sformatf("R2/R3/R4/R6 vector %0d", i),
            {VEC[i].pic, VEC[i].io}, {VEC[i].pic, VEC[i].io} & 0 | {pic_irq, ioapic_irq});
      step();
      tmr_evt = 0;
    end
    repeat (3) step();
    legacy_en = 0;

    // R5 level held, edge pulse one cycle
    route_sel = {5'd12,5'd11,5'd21,5'd20}; msg_en = 0; tmr_level = 4'b0100;
    tmr_evt = 4'b0100;
    repeat (3) step();
    #1; check("R5 level line held", ioapic_irq[11], 1);
    tmr_evt = 0; #1;
    check("R5 level line drops", ioapic_irq[11], 0);
    step(); tmr_level = 0; tmr_evt = 4'b0001; #1;
    check("R5 edge pulse", ioapic_irq[20], 1);
    step(); tmr_evt = 0; #1;
    check("R5 edge pulse ends", ioapic_irq[20], 0);

    // R7 single write
    step(); msg_en = 4'b0100; tmr_evt = 4'b0100; #1;
    check("R6 msg timer drives no line", {pic_irq, ioapic_irq}, 0);
    step(); tmr_evt = 0; #1;
    check("R7 write issued", {wr_valid, wr_addr, wr_data}, {1'b1, 32'hFEE0_0020, 32'hA2});
    step(); #1;
    check("R7 exactly one write", wr_valid, 0);

    // R8 priority and stall
    msg_en = 4'b1010; wr_ready = 0; tmr_evt = 4'b1010;
    step(); tmr_evt = 0; #1;
    check("R8 lowest first", {wr_valid, wr_addr}, {1'b1, 32'hFEE0_0010});
    repeat (3) step();
    #1; check("R8 held under stall", {wr_valid, wr_addr, wr_data}, {1'b1, 32'hFEE0_0010, 32'hA1});
    wr_ready = 1;
    step(); #1;
    check("R8 pending issued next", {wr_valid, wr_addr, wr_data}, {1'b1, 32'hFEE0_0030, 32'hA3});
    step(); #1;
    check("R8 queue drained", wr_valid, 0);

    // R9 message in legacy mode
    legacy_en = 1; msg_en = 4'b0001; tmr_evt = 4'b0001; #1;
    check("R9 legacy msg timer silent", {pic_irq[0], ioapic_irq[2]}, 0);
    step(); tmr_evt = 0; #1;
    check("R9 legacy msg write", {wr_valid, wr_addr, wr_data}, {1'b1, 32'hFEE0_0000, 32'hA0});
    step(); #1;
    check("R9 single write", wr_valid, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule